// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This unit carries out the four partial-word access operations that let software touch a word that straddles an aligned boundary. The left and right forms move bytes in opposite directions. Each access goes to the aligned word that contains the byte address. The two low address bits give the byte offset k. Byte lanes are numbered little-endian, with lane 0 in bits 7:0.

A load reads the aligned word. It merges some of that word's bytes into the old value of the destination register and returns the result with a register write enable. A store is a read-modify-write. It reads the aligned word, merges register bytes into it, and writes the merged word back to the same aligned address. A request is taken only while the unit is idle. Memory phases wait for a ready handshake, and `done` marks the end of every request.

Top module: `unaligned_merge_unit`

## Requirements
- R1: A request is accepted only while `req_ready` is high, which is true only when no access is in progress. `req_valid` raised while busy is ignored: it produces no extra `done` and no memory write.
- R2: Every memory access uses `mem_addr` equal to `req_addr` with its two low bits cleared.
- R3: Opcode 0 (load-left) returns `(reg & M[k]) | (mem << S[k])`, where M = {00FFFFFF, 0000FFFF, 000000FF, 0} and S = {24,16,8,0} for k = 0..3.
- R4: Opcode 1 (load-right) returns `(reg & M[k]) | (mem >> S[k])`, where M = {0, FF000000, FFFF0000, FFFFFF00} and S = {0,8,16,24}.
- R5: Opcode 2 (store-left) writes `(reg >> S[k]) | (mem & M[k])`, where S = {24,16,8,0} and M = {FFFFFF00, FFFF0000, FF000000, 0}. `res_data` carries the written word.
- R6: Opcode 3 (store-right) writes `(reg << S[k]) | (mem & M[k])`, where S = {0,8,16,24} and M = {0, FF, FFFF, FFFFFF}. `res_data` carries the written word.
- R7: A store makes exactly one read and then exactly one write to the same aligned address. A load makes exactly one read and no write.
- R8: `res_wen` is high only with `done` for a load whose destination index is nonzero. For a store it stays low. `res_dst` echoes the request index.
- R9: `done` is a single-cycle pulse, once per accepted request.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady.
- R11: Load-left at k=3 and load-right at k=0 return the whole memory word. Store-left at k=3 and store-right at k=0 write the whole register word.
- R12: After reset `req_ready` is high and `done`, `mem_req` and `res_wen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| req_addr | input | ADDR_W | Byte address |
| req_reg | input | DATA_W | Old destination value (loads) or source value (stores) |
| req_dst | input | IDX_W | Destination register index |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Aligned word byte address |
| mem_wdata | output | DATA_W | Merged store word |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Memory accepts/completes the access this cycle |
| done | output | 1 | Request finished (one cycle) |
| res_data | output | DATA_W | Load result or written store word |
| res_wen | output | 1 | Register write enable |
| res_dst | output | IDX_W | Register index for the result |

## Verification
Two things can coincide in the same cycle: a new `req_valid` and a read-modify-write that is still in flight. The bench slows memory so that a store sits between its read and its write, and it raises a conflicting request during that gap. Success means the scoreboard sees no `done` it did not expect, and a final sweep of the modelled memory matches the reference image. The other overlap is a stalled memory phase meeting a change of `mem_ready`. The same store and load vectors are run with memory always ready and again with a ready every third cycle, and the results must agree.

// File: rtl/umu_pkg.sv
package umu_pkg;
   typedef enum logic [1:0] {
      UOP_LOAD_LEFT   = 2'd0,
      UOP_LOAD_RIGHT  = 2'd1,
      UOP_STORE_LEFT  = 2'd2,
      UOP_STORE_RIGHT = 2'd3
   } umu_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_MERGE = 3'd2,
      ST_WRITE = 3'd3,
      ST_DONE  = 3'd4
   } umu_state_e;

   function automatic logic op_is_store(input umu_op_e op);
      return op[1];
   endfunction

   function automatic logic op_is_right(input umu_op_e op);
      return op[0];
   endfunction
endpackage

// File: rtl/umu_ctrl.sv
module umu_ctrl
   import umu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic store_q,
   input  logic mem_ready,
   output logic req_ready,
   output logic accept,
   output logic rd_capture,
   output logic wd_capture,
   output logic mem_req,
   output logic mem_we,
   output logic done
);
   umu_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_READ;
         ST_READ:  if (mem_ready) state_d = store_q ? ST_MERGE : ST_DONE;
         ST_MERGE: state_d = ST_WRITE;
         ST_WRITE: if (mem_ready) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_ready & req_valid;
   assign rd_capture = (state_q == ST_READ) & mem_ready;
   assign wd_capture = (state_q == ST_MERGE);
   assign mem_req    = (state_q == ST_READ) | (state_q == ST_WRITE);
   assign mem_we     = (state_q == ST_WRITE);
   assign done       = (state_q == ST_DONE);
endmodule

// File: rtl/umu_merge.sv
module umu_merge
   import umu_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES),
   localparam int SH_W  = OFS_W + 3
) (
   input  umu_op_e           op,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [DATA_W-1:0] mem_word,
   output logic [DATA_W-1:0] load_res,
   output logic [DATA_W-1:0] store_res
);
   logic [SH_W-1:0]   sh_fwd, sh_rev;
   logic [DATA_W-1:0] mem_up, mem_dn, reg_dn, reg_up;
   logic [DATA_W-1:0] ld_left, ld_right, st_left, st_right;

   // byte offset k and its complement (LANES-1-k) as bit shift counts
   assign sh_fwd = {ofs, 3'b000};
   assign sh_rev = {~ofs, 3'b000};

   assign mem_up = mem_word << sh_rev;
   assign mem_dn = mem_word >> sh_fwd;
   assign reg_dn = reg_val  >> sh_rev;
   assign reg_up = reg_val  << sh_fwd;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [OFS_W-1:0] LI = OFS_W'(i);
      assign ld_left [8*i +: 8] = (LI >= ~ofs) ? mem_up[8*i +: 8] : reg_val [8*i +: 8];
      assign ld_right[8*i +: 8] = (LI <= ~ofs) ? mem_dn[8*i +: 8] : reg_val [8*i +: 8];
      assign st_left [8*i +: 8] = (LI <=  ofs) ? reg_dn[8*i +: 8] : mem_word[8*i +: 8];
      assign st_right[8*i +: 8] = (LI >=  ofs) ? reg_up[8*i +: 8] : mem_word[8*i +: 8];
   end

   assign load_res  = op_is_right(op) ? ld_right : ld_left;
   assign store_res = op_is_right(op) ? st_right : st_left;
endmodule

// File: rtl/unaligned_merge_unit.sv
module unaligned_merge_unit
   import umu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_reg,
   input  logic [IDX_W-1:0]  req_dst,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              done,
   output logic [DATA_W-1:0] res_data,
   output logic              res_wen,
   output logic [IDX_W-1:0]  res_dst
);
   localparam int LANES = DATA_W / 8;
   localparam int OFS_W = $clog2(LANES);

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if ((1 << OFS_W) != LANES) begin : g_bad_lanes
      $error("DATA_W/8 must be a power of two");
   end
   if (ADDR_W <= OFS_W || IDX_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the offset width and IDX_W must be positive");
   end

   umu_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] reg_q, rd_q, wd_q;
   logic [IDX_W-1:0]  dst_q;
   logic              accept, rd_capture, wd_capture;
   logic [DATA_W-1:0] load_res, store_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= UOP_LOAD_LEFT;
         addr_q <= '0;
         reg_q  <= '0;
         dst_q  <= '0;
      end else if (accept) begin
         op_q   <= umu_op_e'(req_op);
         addr_q <= req_addr;
         reg_q  <= req_reg;
         dst_q  <= req_dst;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rd_q <= '0;
      else if (rd_capture) rd_q <= mem_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wd_q <= '0;
      else if (wd_capture) wd_q <= store_res;
   end

   umu_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .store_q    (op_is_store(op_q)),
      .mem_ready  (mem_ready),
      .req_ready  (req_ready),
      .accept     (accept),
      .rd_capture (rd_capture),
      .wd_capture (wd_capture),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .done       (done)
   );

   umu_merge #(.DATA_W(DATA_W)) u_merge (
      .op        (op_q),
      .ofs       (addr_q[OFS_W-1:0]),
      .reg_val   (reg_q),
      .mem_word  (rd_q),
      .load_res  (load_res),
      .store_res (store_res)
   );

   assign mem_addr  = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
   assign mem_wdata = wd_q;
   assign res_data  = op_is_store(op_q) ? wd_q : load_res;
   assign res_wen   = done & ~op_is_store(op_q) & (dst_q != '0);
   assign res_dst   = dst_q;
endmodule

// File: rtl/umu_checker.sv
module umu_checker #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ready,
   input logic              done,
   input logic              res_wen,
   input logic [IDX_W-1:0]  res_dst
);
   localparam int OFS_W = $clog2(DATA_W / 8);

   assert_idle_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req && !done);

   assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[OFS_W-1:0] == '0);

   assert_write_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ready) |=> done);

   assert_wen_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_wen |-> done && res_dst != '0);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && (!mem_we || $stable(mem_wdata)));
endmodule

bind unaligned_merge_unit umu_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .done      (done),
   .res_wen   (res_wen),
   .res_dst   (res_dst)
);

// File: tb/sim_unaligned_merge_unit.sv
`timescale 1ns/1ps
module sim_unaligned_merge_unit;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        req_valid = 0;
   logic        req_ready;
   logic [1:0]  req_op = 0;
   logic [31:0] req_addr = 0;
   logic [31:0] req_reg = 0;
   logic [4:0]  req_dst = 0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1;
   logic        done;
   logic [31:0] res_data;
   logic        res_wen;
   logic [4:0]  res_dst;

   always #5 clk = ~clk;

   unaligned_merge_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_reg(req_reg), .req_dst(req_dst),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done),
      .res_data(res_data), .res_wen(res_wen), .res_dst(res_dst)
   );

   typedef struct {
      logic [1:0]  op;
      logic [31:0] addr;
      logic [31:0] exp;
      logic [4:0]  dst;
      logic        edge_k;
   } item_t;

   item_t       sbq[$];
   logic [31:0] mem [16];
   logic [31:0] ref_mem [16];
   int          n_chk = 0, n_fail = 0;
   int          stall_mode = 0, cyc = 0, wd = 0;
   int          rd_cnt = 0, wr_cnt = 0;

   assign mem_rdata = mem[mem_addr[5:2]];

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: ready pattern set just after each edge
   always @(posedge clk) begin
      if (mem_req && mem_we && mem_ready) mem[mem_addr[5:2]] <= mem_wdata;
      #2;
      cyc++;
      mem_ready = (stall_mode == 0) ? 1'b1 : (cyc % 3 == 0);
   end

   // reference formulas
   function automatic logic [31:0] model(input logic [1:0] op, input logic [1:0] k,
                                         input logic [31:0] r, input logic [31:0] m);
      case (op)
         2'd0: case (k)
            2'd0: return (r & 32'h00FFFFFF) | (m << 24);
            2'd1: return (r & 32'h0000FFFF) | (m << 16);
            2'd2: return (r & 32'h000000FF) | (m << 8);
            default: return m;
         endcase
         2'd1: case (k)
            2'd0: return m;
            2'd1: return (r & 32'hFF000000) | (m >> 8);
            2'd2: return (r & 32'hFFFF0000) | (m >> 16);
            default: return (r & 32'hFFFFFF00) | (m >> 24);
         endcase
         2'd2: case (k)
            2'd0: return (r >> 24) | (m & 32'hFFFFFF00);
            2'd1: return (r >> 16) | (m & 32'hFFFF0000);
            2'd2: return (r >> 8)  | (m & 32'hFF000000);
            default: return r;
         endcase
         default: case (k)
            2'd0: return r;
            2'd1: return (r << 8)  | (m & 32'h000000FF);
            2'd2: return (r << 16) | (m & 32'h0000FFFF);
            default: return (r << 24) | (m & 32'h00FFFFFF);
         endcase
      endcase
   endfunction

   task automatic issue(input logic [1:0] op, input logic [31:0] addr,
                        input logic [31:0] rv, input logic [4:0] dst);
      item_t it;
      it.op     = op;
      it.addr   = addr;
      it.dst    = dst;
      it.exp    = model(op, addr[1:0], rv, ref_mem[addr[5:2]]);
      it.edge_k = ((op == 2'd0 || op == 2'd2) && addr[1:0] == 2'd3) ||
                  ((op == 2'd1 || op == 2'd3) && addr[1:0] == 2'd0);
      if (op[1]) ref_mem[addr[5:2]] = it.exp;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      sbq.push_back(it);
      req_valid = 1; req_op = op; req_addr = addr; req_reg = rv; req_dst = dst;
      @(negedge clk);
      req_valid = 0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_ready) begin
            if (mem_we) wr_cnt++; else rd_cnt++;
            if (sbq.size() > 0)
               check(mem_addr == {sbq[0].addr[31:2], 2'b00}, "R2 mem_addr",
                     mem_addr, {sbq[0].addr[31:2], 2'b00});
         end
         if (done) begin
            if (sbq.size() == 0) begin
               check(1'b0, "R1 unexpected done", 32'd1, 32'd0);
            end else begin
               item_t it;
               string tg;
               it = sbq.pop_front();
               tg = it.edge_k ? "R11 " : "";
               case (it.op)
                  2'd0: tg = {tg, "R3 load-left"};
                  2'd1: tg = {tg, "R4 load-right"};
                  2'd2: tg = {tg, "R5 store-left"};
                  default: tg = {tg, "R6 store-right"};
               endcase
               check(res_data == it.exp, tg, res_data, it.exp);
               if (it.op[1])
                  check(mem[it.addr[5:2]] == it.exp, {tg, " memory"},
                        mem[it.addr[5:2]], it.exp);
               check(res_wen == (!it.op[1] && it.dst != 0), "R8 res_wen",
                     {31'd0, res_wen}, {31'd0, (!it.op[1] && it.dst != 0)});
               check(res_dst == it.dst, "R8 res_dst", {27'd0, res_dst}, {27'd0, it.dst});
               check(rd_cnt == 1 && wr_cnt == (it.op[1] ? 1 : 0), "R7 access count",
                     {rd_cnt[15:0], wr_cnt[15:0]}, {16'd1, 15'd0, it.op[1]});
            end
            rd_cnt = 0; wr_cnt = 0;
         end
      end
   end

   // R9: done never lasts two sampled cycles
   logic done_prev = 0;
   always @(negedge clk) begin
      if (rst_n && done && done_prev) check(1'b0, "R9 done pulse", 32'd2, 32'd1);
      done_prev = done;
   end

   // watchdog
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL R9 watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i]     = 32'h1A2B3C4D ^ (i * 32'h01030507);
         ref_mem[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      // R12: reset values
      check(req_ready == 1'b1, "R12 req_ready", {31'd0, req_ready}, 32'd1);
      check(done == 1'b0 && mem_req == 1'b0 && res_wen == 1'b0, "R12 idle outputs",
            {29'd0, done, mem_req, res_wen}, 32'd0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // all four forms at every offset, memory always ready
      for (int op = 0; op < 4; op++)
         for (int k = 0; k < 4; k++)
            issue(op[1:0], 32'h0000_0100 + 32'(4 * (op * 4 + k) % 64) + 32'(k),
                  32'hA1B2C3D4 + 32'(op * 16 + k), 5'(op * 4 + k));

      // R8: load to index 0 must not enable a write
      issue(2'd0, 32'h0000_0011, 32'hCAFEF00D, 5'd0);
      issue(2'd1, 32'h0000_0022, 32'hDEADBEEF, 5'd0);

      // R10: slow memory, same forms
      stall_mode = 1;
      for (int op = 0; op < 4; op++)
         for (int k = 0; k < 4; k++)
            issue(op[1:0], 32'h0000_0200 + 32'(4 * ((op + k) % 16)) + 32'(k),
                  32'h0F1E2D3C ^ 32'(op * 257 + k), 5'(k + 1));

      // R1: conflicting request raised while a store is in flight
      issue(2'd2, 32'h0000_0305, 32'h55667788, 5'd3);
      req_valid = 1; req_op = 2'd3; req_addr = 32'h0000_0338;
      req_reg = 32'hFFFFFFFF; req_dst = 5'd9;
      check(req_ready == 1'b0, "R1 busy ready", {31'd0, req_ready}, 32'd0);
      repeat (2) @(negedge clk);
      req_valid = 0;
      issue(2'd3, 32'h0000_0306, 32'h99AABBCC, 5'd4);

      // back-to-back store then load of the same word
      stall_mode = 0;
      issue(2'd3, 32'h0000_0042, 32'h01020304, 5'd5);
      issue(2'd0, 32'h0000_0041, 32'h0, 5'd6);
      issue(2'd2, 32'h0000_0043, 32'h0BADCAFE, 5'd7);
      issue(2'd1, 32'h0000_0040, 32'h77777777, 5'd8);

      while (sbq.size() > 0) @(negedge clk);
      repeat (4) @(negedge clk);
      for (int i = 0; i < 16; i++)
         check(mem[i] == ref_mem[i], "R1 final memory image", mem[i], ref_mem[i]);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule